// File: doc/BRIEF.md
# Exception Entry Sequencer

This block starts exception handling for a small 8-bit processor core. It covers three sources: reset, a level-sensitive maskable interrupt request and an edge-sensitive non-maskable interrupt. The core's fetch logic raises `boundary` for one cycle at the end of each instruction. It presents the current program counter, stack pointer and status byte at the same time. The sequencer decides in that cycle whether to start an entry. If it starts one, it holds `busy` high so that the fetch logic stalls.

An interrupt entry writes three bytes to the stack over a byte-wide memory port: the PC high byte, then the PC low byte, then the status byte. It then reads a 16-bit vector in two byte reads. In the last cycle it presents the new PC, stack pointer and status together with a one-cycle `load` strobe. A reset entry skips the stack writes. It loads fixed stack-pointer and status values and pulses `clr_idx` so that the core zeroes its Z index and base-page registers. Read data on `rdata` must be valid in the same cycle as the read request.

When the core reports that the instruction just finished cleared the interrupt mask, a maskable request is held back for one more instruction. An acknowledge pulse marks each maskable entry, so that external logic can drop its request line.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, no stack write and no `load` occur. The first cycle after release reads address 0xFFFC and the next reads 0xFFFD. The third cycle pulses `load` and `clr_idx` with `pc_out` = {byte at 0xFFFD, byte at 0xFFFC}, `sp_out` = 0x01FF and `p_out` = 0x36. In `p_out`, bits 7 to 0 are N, V, E, B, D, I, Z, C, so 0x36 sets E, B, I and Z.
- R2: An interrupt entry writes `pc_in[15:8]` to address SP, `pc_in[7:0]` to SP-1 and the status with bit 4 cleared to SP-2, in three consecutive cycles. SP is the value of `sp_in` at the boundary. `sp_out` is SP-3.
- R3: After the writes the entry reads the vector low byte at the base address and the high byte at base+1. The base is 0xFFFA for a non-maskable entry and 0xFFFE for a maskable one. `pc_out` = {high byte, low byte}.
- R4: For an interrupt entry, `p_out` is the captured status with bit 2 (I) set and bit 3 (D) cleared. All other bits are unchanged.
- R5: An entry takes 7 cycles: the boundary cycle, then 6 cycles with `busy` high. `load` is high in the last of these 6 cycles, and `busy` is low in the next cycle.
- R6: A non-maskable request starts only on a low-to-high change of `nmi_line`. A line held high through a finished entry starts nothing at later boundaries. A non-maskable entry ignores the I bit of `p_in`.
- R7: A high `irq_line` sets a pending request that remains set after the line drops. At a boundary the request is taken only if `p_in[2]` is 0. Taken or masked, the pending request is cleared, so a masked pulse is lost.
- R8: At a boundary with `cli_done` high, no maskable entry starts even when `p_in[2]` is 0. A request still pending is kept and is taken at the next boundary.
- R9: When both requests can be taken at the same boundary, the non-maskable one wins. The maskable request stays pending and is taken at the next boundary.
- R10: `irq_ack` is high for exactly the `load` cycle of a maskable entry. It stays low for non-maskable and reset entries.
- R11: `boundary` pulses that arrive while `busy` is high start no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; releasing it starts the reset-vector load |
| irq_line | input | 1 | Maskable request, level-sensitive |
| nmi_line | input | 1 | Non-maskable request, acts on its rising edge |
| boundary | input | 1 | One-cycle strobe at the end of each instruction |
| cli_done | input | 1 | With `boundary`: the finished instruction cleared I |
| pc_in | input | 16 | Current program counter |
| sp_in | input | 16 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| rdata | input | 8 | Read data, valid in the cycle of the request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Entry in progress; the fetch logic stalls |
| load | output | 1 | New PC, SP and status are valid this cycle |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| p_out | output | 8 | New status byte |
| clr_idx | output | 1 | Clear the Z index and base-page registers (reset only) |
| irq_ack | output | 1 | Maskable request taken |

## Verification
Both request types can be eligible at the same instruction boundary. The bench causes this by raising `irq_line` and giving `nmi_line` a rising edge before one boundary, with the I bit clear. It passes only if that entry reads the 0xFFFA vector with `irq_ack` low, and the next boundary then starts a full maskable entry from 0xFFFE. The mask-clear strobe is a second collision. The bench asserts `cli_done` in the cycle the request would otherwise be taken, checks that nothing starts, and checks that the following boundary does start the entry.

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter logic [15:0] NMI_BASE = 16'hFFFA,
  parameter logic [15:0] RST_BASE = 16'hFFFC,
  parameter logic [15:0] IRQ_BASE = 16'hFFFE,
  parameter logic [15:0] SP_INIT  = 16'h01FF,
  parameter logic [7:0]  P_INIT   = 8'h36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_line,
  input  logic        nmi_line,
  input  logic        boundary,
  input  logic        cli_done,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        busy,
  output logic        load,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic [7:0]  p_out,
  output logic        clr_idx,
  output logic        irq_ack
);

  localparam int BIT_B = 4;
  localparam int BIT_D = 3;
  localparam int BIT_I = 2;

  typedef enum logic [2:0] {S_IDLE, S_PH, S_PL, S_PP, S_VL, S_VH, S_DONE} st_t;
  typedef enum logic [1:0] {K_RST, K_NMI, K_IRQ} kind_t;

  st_t         state;
  kind_t       kind;
  logic [15:0] pc_r, sp_r;
  logic [7:0]  p_r, vlo, vhi;
  logic        nmi_q, nmi_pend, irq_pend;

  wire nmi_now  = nmi_pend | (nmi_line & ~nmi_q);
  wire irq_now  = irq_pend | irq_line;
  wire take_nmi = nmi_now;
  wire take_irq = ~take_nmi & irq_now & ~p_in[BIT_I] & ~cli_done;
  wire pushing  = (state == S_PH) || (state == S_PL) || (state == S_PP);
  wire reading  = (state == S_VL) || (state == S_VH);

  logic [15:0] base;
  always_comb begin
    case (kind)
      K_NMI:   base = NMI_BASE;
      K_IRQ:   base = IRQ_BASE;
      default: base = RST_BASE;
    endcase
  end

  always_comb begin
    case (state)
      S_PH:    mem_wdata = pc_r[15:8];
      S_PL:    mem_wdata = pc_r[7:0];
      S_PP:    mem_wdata = p_r & ~(8'd1 << BIT_B);
      default: mem_wdata = 8'h00;
    endcase
  end

  assign mem_req  = pushing | reading;
  assign mem_we   = pushing;
  assign mem_addr = pushing ? sp_r : (state == S_VH) ? base + 16'd1 : base;
  assign busy     = (state != S_IDLE);
  assign load     = (state == S_DONE);
  assign pc_out   = {vhi, vlo};
  assign sp_out   = sp_r;
  assign p_out    = (kind == K_RST) ? p_r
                  : ((p_r | (8'd1 << BIT_I)) & ~(8'd1 << BIT_D));
  assign clr_idx  = load && (kind == K_RST);
  assign irq_ack  = load && (kind == K_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_VL;
      kind     <= K_RST;
      sp_r     <= SP_INIT;
      p_r      <= P_INIT;
      pc_r     <= '0;
      vlo      <= '0;
      vhi      <= '0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_line;
      case (state)
        S_IDLE: begin
          if (boundary) begin
            nmi_pend <= 1'b0;
            irq_pend <= (take_nmi | cli_done) ? irq_now : 1'b0;
            if (take_nmi | take_irq) begin
              state <= S_PH;
              kind  <= take_nmi ? K_NMI : K_IRQ;
              pc_r  <= pc_in;
              sp_r  <= sp_in;
              p_r   <= p_in;
            end
          end else begin
            nmi_pend <= nmi_now;
            irq_pend <= irq_now;
          end
        end
        S_PH: begin nmi_pend <= nmi_now; sp_r <= sp_r - 16'd1; state <= S_PL; end
        S_PL: begin nmi_pend <= nmi_now; sp_r <= sp_r - 16'd1; state <= S_PP; end
        S_PP: begin nmi_pend <= nmi_now; sp_r <= sp_r - 16'd1; state <= S_VL; end
        S_VL: begin nmi_pend <= nmi_now; vlo <= rdata; state <= S_VH; end
        S_VH: begin nmi_pend <= nmi_now; vhi <= rdata; state <= S_DONE; end
        default: begin nmi_pend <= nmi_now; state <= S_IDLE; end
      endcase
    end
  end

  // R10
  ack_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (load && !clr_idx));

  // R5
  load_ends_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !busy);

  // R4
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr_idx) |-> (p_out[BIT_I] && !p_out[BIT_D]));

  // R1
  reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clr_idx) |-> (sp_out == SP_INIT && p_out == P_INIT));

  // R2
  push_descends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 16'd1));

  // R11
  start_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary));

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, irq_line, nmi_line, boundary, cli_done;
  logic [15:0] pc_in, sp_in;
  logic [7:0]  p_in, rdata;
  logic mem_req, mem_we, busy, load, clr_idx, irq_ack;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata, p_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] vbyte(input logic [15:0] a);
    case (a)
      16'hFFFA: vbyte = 8'h11;
      16'hFFFB: vbyte = 8'h22;
      16'hFFFC: vbyte = 8'h33;
      16'hFFFD: vbyte = 8'h44;
      16'hFFFE: vbyte = 8'h55;
      16'hFFFF: vbyte = 8'h66;
      default:  vbyte = a[7:0] ^ 8'h5A;
    endcase
  endfunction

  assign rdata = vbyte(mem_addr);

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .nmi_line(nmi_line),
    .boundary(boundary), .cli_done(cli_done), .pc_in(pc_in), .sp_in(sp_in),
    .p_in(p_in), .rdata(rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .load(load),
    .pc_out(pc_out), .sp_out(sp_out), .p_out(p_out), .clr_idx(clr_idx),
    .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic entry(input bit is_nmi, input logic [7:0] p, input logic [15:0] pc,
                       input logic [15:0] sp, input bit poke, input string tag);
    logic [15:0] b = is_nmi ? 16'hFFFA : 16'hFFFE;
    logic [15:0] v = is_nmi ? 16'h2211 : 16'h6655;
    @(negedge clk);
    boundary = 1'b1; pc_in = pc; sp_in = sp; p_in = p;
    @(negedge clk);
    boundary = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 0) chk({"R5 ", tag}, "busy", busy, 1);
      if (i < 3) begin
        chk({"R2 ", tag}, "we", mem_we, 1);
        chk({"R2 ", tag}, "addr", mem_addr, sp - 16'(i));
        chk({"R2 ", tag}, "wdata", mem_wdata,
            (i == 0) ? pc[15:8] : (i == 1) ? pc[7:0] : (p & 8'hEF));
      end else if (i < 5) begin
        chk({"R3 ", tag}, "read", {mem_req, mem_we}, 2'b10);
        chk({"R3 ", tag}, "addr", mem_addr, b + 16'(i - 3));
      end else begin
        chk({"R5 ", tag}, "load", load, 1);
        chk({"R3 ", tag}, "pc_out", pc_out, v);
        chk({"R4 ", tag}, "p_out", p_out, (p | 8'h04) & 8'hF7);
        chk({"R2 ", tag}, "sp_out", sp_out, sp - 16'd3);
        chk({"R10 ", tag}, "irq_ack", irq_ack, !is_nmi);
        chk({"R1 ", tag}, "clr_idx", clr_idx, 0);
        if (irq_ack) irq_line = 1'b0;
      end
      if (poke) boundary = (i == 1);
      @(negedge clk);
    end
    chk({"R5 R11 ", tag}, "busy after load", busy, 0);
  endtask

  task automatic no_entry(input logic [7:0] p, input bit cli, input string tag);
    @(negedge clk);
    boundary = 1'b1; p_in = p; cli_done = cli;
    @(negedge clk);
    boundary = 1'b0; cli_done = 1'b0;
    chk(tag, "busy", busy, 0);
    chk(tag, "mem_req", mem_req, 0);
  endtask

  // {is_nmi, p, pc, sp}
  localparam logic [40:0] TBL [4] = '{
    {1'b0, 8'hC1, 16'h1234, 16'h01F0},
    {1'b1, 8'hFF, 16'hABCD, 16'h0180},
    {1'b0, 8'h1A, 16'h8000, 16'h0100},
    {1'b1, 8'h08, 16'h00FF, 16'h01FF}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_line = 1'b0; nmi_line = 1'b0; boundary = 1'b0; cli_done = 1'b0;
    pc_in = '0; sp_in = '0; p_in = '0;
    repeat (3) @(negedge clk);
    chk("R1", "we in reset", mem_we, 0);
    chk("R1", "load in reset", load, 0);
    rst_n = 1'b1;
    #1;
    chk("R1", "addr lo", mem_addr, 16'hFFFC);
    @(negedge clk);
    chk("R1", "addr hi", mem_addr, 16'hFFFD);
    @(negedge clk);
    chk("R1", "load", load, 1);
    chk("R1", "pc_out", pc_out, 16'h4433);
    chk("R1", "sp_out", sp_out, 16'h01FF);
    chk("R1", "p_out", p_out, 8'h36);
    chk("R1", "clr_idx", clr_idx, 1);
    chk("R10", "no ack on reset", irq_ack, 0);
    @(negedge clk);
    chk("R1", "idle after reset", busy, 0);

    for (int k = 0; k < 4; k++) begin
      if (TBL[k][40]) nmi_line = 1'b1; else irq_line = 1'b1;
      entry(TBL[k][40], TBL[k][39:32], TBL[k][31:16], TBL[k][15:0], 1'b0, "table");
      nmi_line = 1'b0;
      @(negedge clk);
    end

    nmi_line = 1'b1;
    entry(1'b1, 8'h04, 16'h2000, 16'h01F8, 1'b0, "R6 edge");
    no_entry(8'h00, 1'b0, "R6 held high");
    nmi_line = 1'b0;
    @(negedge clk);
    nmi_line = 1'b1;
    entry(1'b1, 8'h00, 16'h2002, 16'h01F8, 1'b0, "R6 re-edge");
    nmi_line = 1'b0;
    @(negedge clk);

    irq_line = 1'b1;
    @(negedge clk);
    irq_line = 1'b0;
    no_entry(8'h04, 1'b0, "R7 masked");
    no_entry(8'h00, 1'b0, "R7 masked pulse lost");
    irq_line = 1'b1;
    @(negedge clk);
    irq_line = 1'b0;
    @(negedge clk);
    entry(1'b0, 8'h00, 16'h3000, 16'h01E0, 1'b0, "R7 latched pulse");

    irq_line = 1'b1;
    no_entry(8'h00, 1'b1, "R8 held after cli");
    entry(1'b0, 8'h00, 16'h3100, 16'h01E0, 1'b0, "R8 next boundary");

    irq_line = 1'b1;
    nmi_line = 1'b1;
    entry(1'b1, 8'h00, 16'h4000, 16'h01D0, 1'b0, "R9 nmi first");
    nmi_line = 1'b0;
    entry(1'b0, 8'h00, 16'h4000, 16'h01CD, 1'b0, "R9 irq second");

    nmi_line = 1'b1;
    entry(1'b1, 8'h00, 16'h5000, 16'h01C0, 1'b1, "R11 boundary while busy");
    nmi_line = 1'b0;
    @(negedge clk);
    chk("R11", "still idle", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule